// File: doc/BRIEF.md
# Key-Activity Interrupt Generator

This block turns key-event activity into a single host interrupt line. Two trigger sources run in parallel. A time source counts debounce ticks after each key event and fires once a programmed count is reached. An occupancy source watches the fill level of the key-event FIFO and fires when that level climbs to a programmed threshold. Whichever source is met first raises the interrupt. If both are met, the second leaves the line high.

An 8-bit configuration byte selects both triggers. Bits [4:0] hold the tick count, and bits [7:5] hold half the occupancy threshold. A byte of zero turns the output off. A separate mode input selects how the line clears. In mode 0, any host read of the FIFO clears it. In mode 1, it clears only once the FIFO reports empty. The FIFO, the debouncer and the bus interface sit outside this block.

Top module: `keyirq_gen`

## Requirements
- R1: While the configuration byte is 0x00, `irq_o` is low after every clock edge, including an edge at which the line was high before.
- R2: With bits [4:0] = N (1 to 31), `irq_o` rises at the clock edge where the N-th `tick_i` after a `key_evt_i` is sampled. A value of N = 0 disables the time trigger.
- R3: A new `key_evt_i` restarts the tick count from zero, and a tick sampled in the same cycle as a key event is not counted. The time trigger fires once per key event and stays idle until the next key event.
- R4: With bits [7:5] = F (1 to 7), the threshold is 2F. `irq_o` rises at the edge where `fifo_occ_i` is first sampled at or above the threshold after being below it. An occupancy that stays at or above the threshold does not raise the line again. F = 0 disables the occupancy trigger.
- R5: When both triggers are enabled, the first one met raises `irq_o`. The other trigger can raise it again later if the line has been cleared in between.
- R6: With `clr_mode_i` = 0, `irq_o` is low after the edge at which `fifo_rd_i` is sampled high, unless a trigger fires at that same edge.
- R7: With `clr_mode_i` = 1, `fifo_rd_i` does not clear `irq_o`. The line goes low at the edge where `fifo_occ_i` is sampled as 0.
- R8: A trigger that fires at the same edge as a clear condition leaves `irq_o` high.
- R9: While `rst_n` is low, `irq_o` is low and the tick counter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 8 | Trigger configuration: [4:0] tick count, [7:5] half of the occupancy threshold |
| fifo_occ_i | input | OCC_W (4) | Current key FIFO occupancy |
| key_evt_i | input | 1 | One-cycle pulse per recorded key event |
| tick_i | input | 1 | One-cycle pulse per debounce cycle |
| fifo_rd_i | input | 1 | One-cycle pulse per host FIFO read |
| clr_mode_i | input | 1 | Clear mode: 0 clears on a read, 1 clears when the FIFO is empty |
| irq_o | output | 1 | Host interrupt, active high |

## Verification
The assertions take the strobes to be single-cycle pulses that are synchronous to `clk`. They take `fifo_occ_i` to be a registered value that changes only at clock edges, and `cfg_i` to be held stable while a count is in progress, except where a test changes it on purpose. The bench drives every input just after the falling edge and holds it across exactly one rising edge. It changes the configuration only at step boundaries, so each edge sees one coherent set of inputs.

// File: rtl/keyirq_pkg.sv
package keyirq_pkg;
  localparam int CFG_W  = 8;
  localparam int TIME_W = 5;
  localparam int THR_W  = CFG_W - TIME_W;

  // Tick count carried in the low field of the configuration byte.
  function automatic logic [TIME_W-1:0] time_target(input logic [CFG_W-1:0] cfg);
    return cfg[TIME_W-1:0];
  endfunction

  // Occupancy threshold: the upper field doubled, one bit wider than the field.
  function automatic logic [THR_W:0] fifo_thresh(input logic [CFG_W-1:0] cfg);
    return {cfg[CFG_W-1:TIME_W], 1'b0};
  endfunction

  // Count after one more tick, widened so it cannot wrap.
  function automatic logic [TIME_W:0] next_count(input logic [TIME_W-1:0] cnt);
    return {1'b0, cnt} + 1'b1;
  endfunction
endpackage

// File: rtl/keyirq_timer.sv
module keyirq_timer
  import keyirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_evt_i,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] target_i,
  output logic              fire_o,
  output logic              armed_o
);
  logic              armed_q;
  logic [TIME_W-1:0] cnt_q;
  logic [TIME_W:0]   cnt_nx;

  assign cnt_nx  = next_count(cnt_q);
  assign fire_o  = armed_q & tick_i & ~key_evt_i & (cnt_nx >= {1'b0, target_i});
  assign armed_o = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (key_evt_i) begin
      armed_q <= (target_i != '0);
      cnt_q   <= '0;
    end else if (armed_q && tick_i) begin
      if (fire_o) armed_q <= 1'b0;
      else        cnt_q   <= cnt_nx[TIME_W-1:0];
    end
  end

  // R3: after firing, the counter stays idle until a new key event
  p_stop_after_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !armed_q);
endmodule

// File: rtl/keyirq_fifo_cond.sv
module keyirq_fifo_cond
  import keyirq_pkg::*;
#(
  parameter int OCC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] occ_i,
  input  logic [THR_W:0]   thresh_i,
  output logic             rise_o
);
  logic hit, hit_q;

  assign hit    = (thresh_i != '0) && ({1'b0, occ_i} >= {{(OCC_W-THR_W){1'b0}}, thresh_i});
  assign rise_o = hit & ~hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit;
  end

  // R4: a level held at or above the threshold yields a single trigger
  p_single_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/keyirq_gen.sv
module keyirq_gen
  import keyirq_pkg::*;
#(
  parameter int OCC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [OCC_W-1:0] fifo_occ_i,
  input  logic             key_evt_i,
  input  logic             tick_i,
  input  logic             fifo_rd_i,
  input  logic             clr_mode_i,
  output logic             irq_o
);
  logic time_fire, fifo_rise, timer_armed;
  logic set_evt, clr_evt, enabled, irq_q;

  keyirq_timer u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_evt_i (key_evt_i),
    .tick_i    (tick_i),
    .target_i  (time_target(cfg_i)),
    .fire_o    (time_fire),
    .armed_o   (timer_armed)
  );

  keyirq_fifo_cond #(.OCC_W(OCC_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .occ_i    (fifo_occ_i),
    .thresh_i (fifo_thresh(cfg_i)),
    .rise_o   (fifo_rise)
  );

  assign enabled = (cfg_i != '0);
  assign set_evt = time_fire | fifo_rise;
  assign clr_evt = clr_mode_i ? (fifo_occ_i == '0) : fifo_rd_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_q <= 1'b0;
    else if (!enabled) irq_q <= 1'b0;
    else if (set_evt)  irq_q <= 1'b1;
    else if (clr_evt)  irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  // R1: an all-zero configuration forces the line low
  p_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i == '0) |=> !irq_o);

  // R8: a trigger wins over a clear in the same cycle
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && enabled) |=> irq_o);

  // R6: in read-clear mode, a read with no trigger drops the line
  p_mode0_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && fifo_rd_i && !clr_mode_i && !set_evt) |=> !irq_o);

  // R7: in empty-clear mode, the line holds while the FIFO is not empty
  p_mode1_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && clr_mode_i && enabled && (fifo_occ_i != '0)) |=> irq_o);

  // R9: reset leaves the counter idle
  p_reset_idle_r9: assert property (@(posedge clk)
    !rst_n |-> !timer_armed && !irq_o);
endmodule

// File: tb/keyirq_gen_bench.sv
`timescale 1ns/1ps
module keyirq_gen_bench;
  typedef struct packed {
    logic [7:0] cfg;
    logic       mode;
    logic       key;
    logic       tick;
    logic       rd;
    logic [3:0] occ;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{8'h03,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,4'd2}, // R2 idle
    '{8'h03,1'b0,1'b1,1'b0,1'b0,4'd0,1'b0,4'd2}, // R2 key
    '{8'h03,1'b0,1'b0,1'b1,1'b0,4'd0,1'b0,4'd2}, // R2 tick 1
    '{8'h03,1'b0,1'b0,1'b1,1'b0,4'd0,1'b0,4'd2}, // R2 tick 2
    '{8'h03,1'b0,1'b0,1'b1,1'b0,4'd0,1'b1,4'd2}, // R2 tick 3 fires
    '{8'h03,1'b0,1'b0,1'b1,1'b0,4'd0,1'b1,4'd2}, // R2 stays high
    '{8'h03,1'b0,1'b0,1'b0,1'b1,4'd0,1'b0,4'd6}, // R6 read clears
    '{8'h03,1'b0,1'b0,1'b1,1'b0,4'd0,1'b0,4'd3}, // R3 no refire
    '{8'h03,1'b0,1'b0,1'b1,1'b0,4'd0,1'b0,4'd3}, // R3
    '{8'h03,1'b0,1'b0,1'b1,1'b0,4'd0,1'b0,4'd3}, // R3
    '{8'h03,1'b0,1'b1,1'b0,1'b0,4'd0,1'b0,4'd3}, // R3 key
    '{8'h03,1'b0,1'b0,1'b1,1'b0,4'd0,1'b0,4'd3}, // R3 tick 1
    '{8'h03,1'b0,1'b0,1'b1,1'b0,4'd0,1'b0,4'd3}, // R3 tick 2
    '{8'h03,1'b0,1'b1,1'b1,1'b0,4'd0,1'b0,4'd3}, // R3 restart, tick ignored
    '{8'h03,1'b0,1'b0,1'b1,1'b0,4'd0,1'b0,4'd3}, // R3 tick 1
    '{8'h03,1'b0,1'b0,1'b1,1'b0,4'd0,1'b0,4'd3}, // R3 tick 2
    '{8'h03,1'b0,1'b0,1'b1,1'b0,4'd0,1'b1,4'd3}, // R3 tick 3 fires
    '{8'h03,1'b0,1'b0,1'b0,1'b1,4'd0,1'b0,4'd6}, // R6
    '{8'h40,1'b1,1'b0,1'b0,1'b0,4'd3,1'b0,4'd4}, // R4 below 4
    '{8'h40,1'b1,1'b0,1'b0,1'b0,4'd4,1'b1,4'd4}, // R4 reaches 4
    '{8'h40,1'b1,1'b0,1'b0,1'b1,4'd3,1'b1,4'd7}, // R7 read does not clear
    '{8'h40,1'b1,1'b0,1'b0,1'b0,4'd5,1'b1,4'd7}, // R7
    '{8'h40,1'b1,1'b0,1'b0,1'b0,4'd0,1'b0,4'd7}, // R7 empty clears
    '{8'h40,1'b1,1'b0,1'b0,1'b0,4'd4,1'b1,4'd4}, // R4 crossing again
    '{8'h40,1'b0,1'b0,1'b0,1'b1,4'd4,1'b0,4'd6}, // R6 read clears
    '{8'h40,1'b0,1'b0,1'b0,1'b0,4'd6,1'b0,4'd4}, // R4 no re-raise above
    '{8'h25,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,4'd5}, // R5 both on
    '{8'h25,1'b0,1'b1,1'b0,1'b0,4'd0,1'b0,4'd5}, // R5 key
    '{8'h25,1'b0,1'b0,1'b1,1'b0,4'd2,1'b1,4'd5}, // R5 occupancy first
    '{8'h25,1'b0,1'b0,1'b1,1'b1,4'd1,1'b0,4'd5}, // R5 read clears
    '{8'h25,1'b0,1'b0,1'b1,1'b0,4'd1,1'b0,4'd5}, // R5 tick 3
    '{8'h25,1'b0,1'b0,1'b1,1'b0,4'd1,1'b0,4'd5}, // R5 tick 4
    '{8'h25,1'b0,1'b0,1'b1,1'b0,4'd1,1'b1,4'd5}  // R5 tick 5, time trigger
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic [3:0] occ = 4'd0;
  logic       key = 1'b0, tick = 1'b0, rd = 1'b0, mode = 1'b0;
  logic       irq;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  keyirq_gen u_keyirq_gen (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .fifo_occ_i(occ),
    .key_evt_i(key), .tick_i(tick), .fifo_rd_i(rd), .clr_mode_i(mode),
    .irq_o(irq)
  );

  task automatic check(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s: irq_o=%b expected %b", tag, irq, exp);
    end
  endtask

  task automatic apply(input vec_t v, input string tag);
    @(negedge clk);
    cfg = v.cfg; mode = v.mode; key = v.key; tick = v.tick; rd = v.rd; occ = v.occ;
    @(posedge clk); #1;
    check(v.exp, tag);
  endtask

  function automatic vec_t mk(input logic [7:0] c, input logic m, input logic k,
                              input logic t, input logic r, input logic [3:0] o,
                              input logic e);
    return '{c, m, k, t, r, o, e, 4'd0};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cfg = 8'h41; occ = 4'd9; key = 1'b1;
    repeat (3) @(posedge clk);
    #1 check(1'b0, "R9 reset holds irq low");
    @(negedge clk); key = 1'b0; occ = 4'd0; cfg = 8'h00; rst_n = 1'b1;
    @(posedge clk); #1 check(1'b0, "R9 after reset");

    for (int i = 0; i < NV; i++)
      apply(VEC[i], $sformatf("R%0d vector %0d", VEC[i].req, i));

    // R1: zero configuration clears a high line and blocks both triggers
    apply(mk(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 1'b0), "R1 disable clears");
    apply(mk(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1, 1'b0), "R1 key");
    apply(mk(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'd14, 1'b0), "R1 occupancy full");
    apply(mk(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0), "R1 idle");

    // R4: upper field zero disables the occupancy trigger
    apply(mk(8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 4'd14, 1'b0), "R4 F=0 disabled");
    apply(mk(8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0), "R4 F=0 idle");

    // R4: largest threshold is 14
    apply(mk(8'hE0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd13, 1'b0), "R4 13 below 14");
    apply(mk(8'hE0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd14, 1'b1), "R4 reaches 14");
    apply(mk(8'hE0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0), "R6 clear");

    // R2: largest count, 31 ticks
    apply(mk(8'h1F, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0), "R2 key for 31");
    for (int t = 1; t < 31; t++)
      apply(mk(8'h1F, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0), $sformatf("R2 tick %0d of 31", t));
    apply(mk(8'h1F, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b1), "R2 tick 31 fires");
    apply(mk(8'h1F, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0), "R6 clear");

    // R8: a trigger and a read at the same edge leave the line high
    apply(mk(8'h41, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 1'b1), "R8 occupancy raises");
    apply(mk(8'h41, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4, 1'b1), "R8 key");
    apply(mk(8'h41, 1'b0, 1'b0, 1'b1, 1'b1, 4'd4, 1'b1), "R8 fire with read");
    apply(mk(8'h41, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4, 1'b0), "R6 plain read");

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule